// File: doc/BRIEF.md
# Multi-register stack push sequencer

This block carries out a push-multiple operation for a small CPU with sixteen 20-bit registers. On a start strobe it takes a register count, the index of the highest register to save, a width mode and the current stack pointer. It then reads the register file through a single read port and writes the registers downward onto a stack made of 16-bit words. In word mode each register takes one word. In wide mode each register takes two words: the high part comes first, at the higher address.

Every write uses pre-decrement, and the sequencer issues one word per clock. When the last write has gone out, it pulses done and presents the final stack pointer for the owner of that register to take. A malformed request raises an error pulse and writes nothing.

Top module: `pushm_seq`

## Requirements
- R1: A start with count 0, count above 16, or a first register index below count − 1 is rejected. `err` is high for exactly the cycle after the start, and no memory write and no `done` follow.
- R2: Registers are stored from `first_reg` downward, one index per register. With count 5 and index 13 the order is R13, R12, R11, R10, R9.
- R3: In word mode (`wide`=0) there are exactly `count` writes. Write k (k = 1 upward) goes to address `sp_in` − 2k and carries bits 15:0 of its register. The final stack pointer is `sp_in` − 2·count.
- R4: In wide mode (`wide`=1) there are exactly 2·count writes. For each register, the high word is written first and holds bits 19:16 in bits 3:0, with bits 15:4 zero. The low word, bits 15:0, follows at the address 2 below. The final stack pointer is `sp_in` − 4·count.
- R5: Writes use pre-decrement and occur on consecutive cycles. The first write is in the cycle after the accepted start and goes to `sp_in` − 2. Each later write goes 2 below the previous one.
- R6: `done` is high for one cycle only, in the cycle right after the last write. In that cycle `sp_out` equals the address of the last write.
- R7: A start that arrives while an operation is in progress is ignored. The running operation's writes are unchanged, and no further writes follow its `done`.
- R8: When the stack-pointer register (index 1) falls inside the pushed range, the value stored for it is `sp_in` as sampled at the accepted start, not the register file's content.
- R9: After reset, `mem_we`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| count | input | 5 | Number of registers to push |
| first_reg | input | 4 | Index of the first (highest) register pushed |
| wide | input | 1 | 1 = two words per register, 0 = one word |
| sp_in | input | 20 | Stack pointer before the operation |
| rf_addr | output | 4 | Register file read index |
| rf_data | input | 20 | Register file read data (combinational) |
| mem_addr | output | 20 | Word write address |
| mem_data | output | 16 | Word write data |
| mem_we | output | 1 | Word write enable |
| sp_out | output | 20 | Updated stack pointer, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The bench covers the edges of the accepted range:

- A full 16-register push from R15. A design that rejects it, or stops one register short, leaves the stack incomplete.
- Count 0, count 17, and an index one below count − 1. A faulty check here either writes garbage below R0 or refuses a legal push.
- Wide pushes, which show a swapped high and low word or a wrong step of the stack pointer as misplaced words and a wrong final pointer.

It also pushes ranges that contain the stack-pointer register, where a design reading the register file would store a stale value. It fires a second start in mid-operation, which a design lacking the busy guard would turn into extra or corrupted writes.

// File: rtl/pushm_seq.sv
module pushm_seq #(
  parameter int NREG   = 16,
  parameter int RW     = 20,
  parameter int AW     = 20,
  parameter int SP_IDX = 1,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic [IW-1:0] first_reg,
  input  logic          wide,
  input  logic [AW-1:0] sp_in,
  output logic [IW-1:0] rf_addr,
  input  logic [RW-1:0] rf_data,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_data,
  output logic          mem_we,
  output logic [AW-1:0] sp_out,
  output logic          done,
  output logic          err
);

  logic          busy, hi_next, wide_q;
  logic [IW-1:0] idx;
  logic [CW-1:0] left;
  logic [AW-1:0] sp, sp0;
  logic [RW-1:0] value;
  logic          bad, accept;

  assign bad = (count == '0)
            || ((CW+1)'(count) > (CW+1)'(NREG))
            || ((CW+1)'(first_reg) < ((CW+1)'(count) - (CW+1)'(1)));
  assign accept = start && !busy && !bad;

  assign rf_addr  = idx;
  assign value    = (idx == IW'(SP_IDX)) ? RW'(sp0) : rf_data;
  assign mem_data = hi_next ? 16'(value[RW-1:16]) : value[15:0];
  assign mem_addr = sp - AW'(2);
  assign mem_we   = busy;
  assign sp_out   = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      hi_next <= 1'b0;
      wide_q  <= 1'b0;
      idx     <= '0;
      left    <= '0;
      sp      <= '0;
      sp0     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= start && !busy && bad;
      if (accept) begin
        busy    <= 1'b1;
        sp      <= sp_in;
        sp0     <= sp_in;
        idx     <= first_reg;
        left    <= count;
        wide_q  <= wide;
        hi_next <= wide;
      end else if (busy) begin
        sp <= mem_addr;
        if (hi_next) begin
          hi_next <= 1'b0;
        end else begin
          hi_next <= wide_q;
          idx     <= idx - IW'(1);
          left    <= left - CW'(1);
          if (left == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pushm_seq_chk.sv
module pushm_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] sp_in,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [AW-1:0] sp_out,
  input logic          done,
  input logic          err
);

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_we) && !mem_we));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_sp_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sp_out == $past(mem_addr)));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(2)));

  a_r5_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (mem_addr == $past(sp_in) - AW'(2)));

  a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_we && !done));

  a_r1_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !mem_we);

endmodule

bind pushm_seq pushm_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp_in(sp_in), .mem_addr(mem_addr),
  .mem_we(mem_we), .sp_out(sp_out), .done(done), .err(err)
);

// File: tb/tb_pushm_seq.sv
module tb_pushm_seq;
  logic        clk = 0, rst_n = 0, start = 0, wide = 0;
  logic [4:0]  count = 0;
  logic [3:0]  first_reg = 0, rf_addr;
  logic [19:0] sp_in = 0, rf_data, mem_addr, sp_out;
  logic [15:0] mem_data;
  logic        mem_we, done, err;

  logic [19:0] regs [16];
  assign rf_data = regs[rf_addr];

  pushm_seq dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [19:0] waddr [64];
  logic [15:0] wdata [64];
  int          wcyc  [64];
  int          wn = 0, dn = 0, en = 0, done_cyc = 0, start_cyc = 0;
  logic [19:0] sp_seen;

  always @(negedge clk) begin
    if (mem_we && wn < 64) begin
      waddr[wn] = mem_addr; wdata[wn] = mem_data; wcyc[wn] = cyc; wn++;
    end
    if (done) begin dn++; done_cyc = cyc; sp_seen = sp_out; end
    if (err) en++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input int n, input int r, input logic w, input logic [19:0] sp);
    @(negedge clk);
    wn = 0; dn = 0; en = 0;
    count = 5'(n); first_reg = 4'(r); wide = w; sp_in = sp; start = 1;
    start_cyc = cyc;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end();
    for (int t = 0; t < 100 && dn == 0 && en == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_push(input string req, input int n, input int r, input logic w,
                             input logic [19:0] sp);
    int k = 0;
    chk({req, " write count"}, wn, w ? 2 * n : n);
    for (int i = 0; i < n; i++) begin
      logic [19:0] v;
      v = ((r - i) == 1) ? sp : regs[r - i];
      if (w) begin
        chk({req, " hi addr"}, waddr[k], sp - 20'(4 * i + 2));
        chk({req, " hi data"}, wdata[k], {12'h000, v[19:16]});
        k++;
        chk({req, " lo addr"}, waddr[k], sp - 20'(4 * i + 4));
        chk({req, " lo data"}, wdata[k], v[15:0]);
        k++;
      end else begin
        chk({req, " addr"}, waddr[k], sp - 20'(2 * i + 2));
        chk({req, " data"}, wdata[k], v[15:0]);
        k++;
      end
    end
    chk({req, " R5 first write cycle"}, wcyc[0], start_cyc + 1);
    chk({req, " R5 contiguous"}, wcyc[k-1], wcyc[0] + k - 1);
    chk({req, " R6 done count"}, dn, 1);
    chk({req, " R6 done cycle"}, done_cyc, wcyc[k-1] + 1);
    chk({req, " R6 sp_out"}, sp_seen, sp - 20'((w ? 4 : 2) * n));
  endtask

  task automatic t_reset();
    chk("R9 mem_we", mem_we, 0);
    chk("R9 done", done, 0);
    chk("R9 err", err, 0);
  endtask

  task automatic t_word(input int n, input int r, input logic [19:0] sp);
    launch(n, r, 0, sp); wait_end();
    expect_push("R2 R3 word", n, r, 0, sp);
  endtask

  task automatic t_wide(input int n, input int r, input logic [19:0] sp);
    launch(n, r, 1, sp); wait_end();
    expect_push("R2 R4 wide", n, r, 1, sp);
  endtask

  task automatic t_reject(input int n, input int r);
    launch(n, r, 1, 20'h03000);
    chk("R1 err pulse", err, 1);
    @(negedge clk);
    chk("R1 err one cycle", err, 0);
    repeat (4) @(negedge clk);
    chk("R1 no writes", wn, 0);
    chk("R1 no done", dn, 0);
    chk("R1 err count", en, 1);
  endtask

  task automatic t_sp_in_range();
    regs[1] = 20'hABCDE;
    launch(3, 2, 0, 20'h54000); wait_end();
    expect_push("R8 word", 3, 2, 0, 20'h54000);
    launch(2, 1, 1, 20'h54000); wait_end();
    expect_push("R8 wide", 2, 1, 1, 20'h54000);
  endtask

  task automatic t_busy();
    launch(4, 7, 0, 20'h02200);
    @(negedge clk);
    count = 5'd2; first_reg = 4'd3; wide = 1; sp_in = 20'h09000; start = 1;
    @(negedge clk);
    start = 0;
    wait_end();
    repeat (5) @(negedge clk);
    expect_push("R7 ignored", 4, 7, 0, 20'h02200);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = {4'(i + 3), 16'(16'hA000 + i * 16'h0111)};
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_word(5, 13, 20'h01000);
    t_wide(5, 13, 20'h01000);
    t_word(16, 15, 20'h08000);
    t_wide(16, 15, 20'h0C000);
    t_word(1, 0, 20'h00100);
    t_wide(1, 9, 20'h00100);
    t_reject(0, 5);
    t_reject(17, 15);
    t_reject(5, 3);
    t_word(5, 4, 20'h01800);
    t_sp_in_range();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule